// File: doc/BRIEF.md
# Output Voltage Fault Supervisor

This block supervises the output bus of a programmable supply. It takes digitized bus voltage codes (one code per valid strobe) and the code of the voltage the supply has been asked to produce. It flags an under-voltage fault when the bus stays too far below that target, and an over-voltage fault when the bus stays too far above it or above a fixed ceiling. Every fault condition must persist for a qualification time, counted on a 1 ms tick, before it is reported.

When the target changes, the detector that the change would falsely trigger is blanked for a while. A rise in target blanks under-voltage detection. A fall in target blanks over-voltage detection and also disables the synchronous-rectifier gate. The length of the second window depends on the size of the step and on whether the bus was high or low. A reported fault opens the load switch, keeps it open for a fixed restart interval, and then closes it again. After reset the switch stays open until a sample shows a healthy bus.

With the default scale, one code is 25 mV. The ceiling is therefore code 980 (24.5 V), the high-bus limit is code 520 (13 V) and the small-step limit is 20 codes (0.5 V). All durations are counted in ticks.

Top module: `vbus_fault_supervisor`

## Requirements
- R1: Under-voltage condition: a valid sample is strictly below floor(target*70/100). A sample equal to that value is not a fault.
- R2: Over-voltage condition: a valid sample is strictly above floor(target*243/200). A sample equal to that value is not a fault.
- R3: A valid sample strictly above code 980 is an over-voltage condition whatever the target. Code 980 itself is not.
- R4: Qualification of under-voltage: an under-voltage fault is reported after 60 ticks following an under-voltage sample. No fault is reported after 59 ticks.
- R5: Qualification of over-voltage: an over-voltage fault is reported after 31 ticks following an over-voltage sample. No fault is reported after 30 ticks.
- R6: Any valid sample that does not meet a condition clears the qualification of that condition.
- R7: A target-change pulse with a higher target blanks under-voltage detection for 200 ticks. A sample taken inside the window never qualifies.
- R8: A target-change pulse with a lower target blanks over-voltage detection and raises `sr_gate_off`. The window length is chosen from the step (old target minus new) and the last valid sample. It is 7 ticks for a step of at most 20 codes with the sample at or above 520, and 19 ticks for such a step with the sample below 520. It is 56 ticks for a step above 20 codes with the sample at or above 520, and 200 ticks for such a step with the sample below 520.
- R9: A target-change pulse during an open window restarts that window with the length chosen for the new step.
- R10: A reported fault drops `lsw_en` and keeps its flag high for 2000 ticks. After that the flag clears, `lsw_en` returns, and all qualification progress is discarded.
- R11: After reset, `lsw_en`, both flags and `sr_gate_off` are low. `lsw_en` rises on the first valid sample that meets neither condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Strobe marking a new bus voltage code |
| smp_code | input | 10 | Bus voltage code |
| tgt_code | input | 10 | Target voltage code |
| tgt_chg | input | 1 | One-cycle pulse, target code changed in this cycle |
| tick_1ms | input | 1 | One-cycle timebase pulse, once per millisecond |
| uv_fault | output | 1 | Under-voltage fault reported, held through the restart interval |
| ov_fault | output | 1 | Over-voltage fault reported, held through the restart interval |
| lsw_en | output | 1 | Load-switch enable |
| sr_gate_off | output | 1 | Synchronous-rectifier gate disable during an over-voltage blanking window |

## Verification
The properties assume that `tgt_code` moves only in the cycle of a `tgt_chg` pulse. Under that assumption the previous cycle's target is the old target, and the step direction can be read from it. They also assume that `tick_1ms` is a single-cycle pulse, so one restart interval is exactly the count of ticks seen while a flag is high. The bench holds the target steady between change pulses. It drives every sample, tick and target change in its own cycle, so no sample arrives in the same clock as a tick.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

   typedef enum logic [1:0] {
      ST_WAIT = 2'd0,
      ST_ON   = 2'd1,
      ST_HOLD = 2'd2
   } sw_state_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      return max2(max2(a, b), max2(c, d));
   endfunction

endpackage

// File: rtl/vfs_thresh.sv
module vfs_thresh #(
   parameter int unsigned CODE_W    = 10,
   parameter int unsigned UV_NUM    = 70,
   parameter int unsigned UV_DEN    = 100,
   parameter int unsigned OV_NUM    = 243,
   parameter int unsigned OV_DEN    = 200,
   parameter int unsigned CEIL_CODE = 980,
   parameter bit          CEIL_EN   = 1'b1
) (
   input  logic [CODE_W-1:0] tgt_code,
   input  logic [CODE_W-1:0] smp_code,
   output logic              uv_cond,
   output logic              ov_cond
);
   localparam int unsigned NUM_MAX = vfs_pkg::max2(UV_NUM, OV_NUM);
   localparam int unsigned PW      = CODE_W + $clog2(NUM_MAX + 1) + 1;

   logic [PW-1:0] uv_prod, ov_prod, uv_thr, ov_thr, smp_w;
   logic          rel_over, abs_over;

   always_comb begin
      uv_prod = PW'(tgt_code) * PW'(UV_NUM);
      ov_prod = PW'(tgt_code) * PW'(OV_NUM);
      uv_thr  = uv_prod / PW'(UV_DEN);
      ov_thr  = ov_prod / PW'(OV_DEN);
      smp_w   = PW'(smp_code);
   end

   assign uv_cond  = (smp_w < uv_thr);
   assign rel_over = (smp_w > ov_thr);

   generate
      if (CEIL_EN) begin : g_ceiling
         assign abs_over = (smp_w > PW'(CEIL_CODE));
      end else begin : g_no_ceiling
         assign abs_over = 1'b0;
      end
   endgenerate

   assign ov_cond = rel_over | abs_over;

endmodule

// File: rtl/vfs_qualify.sv
module vfs_qualify #(
   parameter int unsigned LIMIT = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic smp_valid,
   input  logic cond,
   input  logic tick,
   output logic trip
);
   localparam int unsigned CW = $clog2(LIMIT + 1);

   logic          armed;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (clr || (smp_valid && !cond)) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else begin
         if (smp_valid) begin
            armed <= 1'b1;
         end
         if (armed && tick && (cnt != CW'(LIMIT))) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign trip = (cnt == CW'(LIMIT));

endmodule

// File: rtl/vfs_blank.sv
module vfs_blank #(
   parameter int unsigned CODE_W       = 10,
   parameter int unsigned INIT_TGT     = 200,
   parameter int unsigned SMALL_STEP   = 20,
   parameter int unsigned HIGH_BUS     = 520,
   parameter int unsigned UV_BLANK     = 200,
   parameter int unsigned OVB_SMALL_HI = 7,
   parameter int unsigned OVB_SMALL_LO = 19,
   parameter int unsigned OVB_BIG_HI   = 56,
   parameter int unsigned OVB_BIG_LO   = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tgt_chg,
   input  logic [CODE_W-1:0] tgt_code,
   input  logic              smp_valid,
   input  logic [CODE_W-1:0] smp_code,
   input  logic              tick,
   output logic              uv_blank,
   output logic              ov_blank
);
   localparam int unsigned OV_MAX = vfs_pkg::max4(OVB_SMALL_HI, OVB_SMALL_LO,
                                                  OVB_BIG_HI, OVB_BIG_LO);
   localparam int unsigned UW = $clog2(UV_BLANK + 1);
   localparam int unsigned OW = $clog2(OV_MAX + 1);

   logic [CODE_W-1:0] tgt_ref, bus_q, step_dn;
   logic [UW-1:0]     uv_cnt;
   logic [OW-1:0]     ov_cnt, ov_len;
   logic              step_up, step_down, small_step, high_bus;

   always_comb begin
      step_up    = (tgt_code > tgt_ref);
      step_down  = (tgt_code < tgt_ref);
      step_dn    = tgt_ref - tgt_code;
      small_step = (step_dn <= CODE_W'(SMALL_STEP));
      high_bus   = (bus_q >= CODE_W'(HIGH_BUS));
      case ({small_step, high_bus})
         2'b11:   ov_len = OW'(OVB_SMALL_HI);
         2'b10:   ov_len = OW'(OVB_SMALL_LO);
         2'b01:   ov_len = OW'(OVB_BIG_HI);
         default: ov_len = OW'(OVB_BIG_LO);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_ref <= CODE_W'(INIT_TGT);
         bus_q   <= '0;
      end else begin
         if (tgt_chg) begin
            tgt_ref <= tgt_code;
         end
         if (smp_valid) begin
            bus_q <= smp_code;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uv_cnt <= '0;
      end else if (tgt_chg && step_up) begin
         uv_cnt <= UW'(UV_BLANK);
      end else if (tick && (uv_cnt != '0)) begin
         uv_cnt <= uv_cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ov_cnt <= '0;
      end else if (tgt_chg && step_down) begin
         ov_cnt <= ov_len;
      end else if (tick && (ov_cnt != '0)) begin
         ov_cnt <= ov_cnt - 1'b1;
      end
   end

   assign uv_blank = (uv_cnt != '0);
   assign ov_blank = (ov_cnt != '0);

endmodule

// File: rtl/vfs_restart.sv
module vfs_restart #(
   parameter int unsigned RESTART_TICKS = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_valid,
   input  logic uv_cond,
   input  logic ov_cond,
   input  logic uv_trip,
   input  logic ov_trip,
   input  logic tick,
   output logic run,
   output logic uv_fault,
   output logic ov_fault
);
   import vfs_pkg::*;

   localparam int unsigned HW = $clog2(RESTART_TICKS + 1);

   sw_state_t     st;
   logic [HW-1:0] hcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_WAIT;
         hcnt     <= '0;
         uv_fault <= 1'b0;
         ov_fault <= 1'b0;
      end else begin
         case (st)
            ST_WAIT: begin
               if (smp_valid && !uv_cond && !ov_cond) begin
                  st <= ST_ON;
               end
            end
            ST_ON: begin
               if (uv_trip || ov_trip) begin
                  st       <= ST_HOLD;
                  hcnt     <= '0;
                  uv_fault <= uv_trip;
                  ov_fault <= ov_trip;
               end
            end
            ST_HOLD: begin
               if (tick) begin
                  if (hcnt == HW'(RESTART_TICKS - 1)) begin
                     st       <= ST_ON;
                     hcnt     <= '0;
                     uv_fault <= 1'b0;
                     ov_fault <= 1'b0;
                  end else begin
                     hcnt <= hcnt + 1'b1;
                  end
               end
            end
            default: st <= ST_WAIT;
         endcase
      end
   end

   assign run = (st == ST_ON);

endmodule

// File: rtl/vbus_fault_supervisor.sv
module vbus_fault_supervisor #(
   parameter int unsigned CODE_W        = 10,
   parameter int unsigned MV_PER_LSB    = 25,
   parameter int unsigned INIT_TGT      = 200,
   parameter int unsigned UV_NUM        = 70,
   parameter int unsigned UV_DEN        = 100,
   parameter int unsigned OV_NUM        = 243,
   parameter int unsigned OV_DEN        = 200,
   parameter bit          CEIL_EN       = 1'b1,
   parameter int unsigned CEIL_MV       = 24500,
   parameter int unsigned HIGH_BUS_MV   = 13000,
   parameter int unsigned SMALL_STEP_MV = 500,
   parameter int unsigned UV_QUAL       = 60,
   parameter int unsigned OV_QUAL       = 31,
   parameter int unsigned UV_BLANK      = 200,
   parameter int unsigned OVB_SMALL_HI  = 7,
   parameter int unsigned OVB_SMALL_LO  = 19,
   parameter int unsigned OVB_BIG_HI    = 56,
   parameter int unsigned OVB_BIG_LO    = 200,
   parameter int unsigned RESTART_TICKS = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [CODE_W-1:0] smp_code,
   input  logic [CODE_W-1:0] tgt_code,
   input  logic              tgt_chg,
   input  logic              tick_1ms,
   output logic              uv_fault,
   output logic              ov_fault,
   output logic              lsw_en,
   output logic              sr_gate_off
);
   localparam int unsigned CEIL_CODE  = CEIL_MV / MV_PER_LSB;
   localparam int unsigned HIGH_BUS   = HIGH_BUS_MV / MV_PER_LSB;
   localparam int unsigned SMALL_STEP = SMALL_STEP_MV / MV_PER_LSB;

   generate
      if (UV_DEN == 0 || OV_DEN == 0 || MV_PER_LSB == 0) begin : g_bad_scale
         $error("vbus_fault_supervisor: zero divisor in scaling parameters");
      end
      if (CEIL_CODE >= (1 << CODE_W) || HIGH_BUS >= (1 << CODE_W)) begin : g_bad_limit
         $error("vbus_fault_supervisor: voltage limit exceeds code range");
      end
      if (UV_QUAL == 0 || OV_QUAL == 0 || RESTART_TICKS == 0) begin : g_bad_time
         $error("vbus_fault_supervisor: qualification and restart times must be nonzero");
      end
      if (UV_NUM >= UV_DEN || OV_NUM <= OV_DEN) begin : g_bad_ratio
         $error("vbus_fault_supervisor: threshold ratios on wrong side of unity");
      end
   endgenerate

   logic uv_cond, ov_cond, uv_blank, ov_blank;
   logic uv_trip, ov_trip, run;
   logic uv_clr, ov_clr;

   vfs_thresh #(
      .CODE_W   (CODE_W),
      .UV_NUM   (UV_NUM),
      .UV_DEN   (UV_DEN),
      .OV_NUM   (OV_NUM),
      .OV_DEN   (OV_DEN),
      .CEIL_CODE(CEIL_CODE),
      .CEIL_EN  (CEIL_EN)
   ) i_thresh (
      .tgt_code(tgt_code),
      .smp_code(smp_code),
      .uv_cond (uv_cond),
      .ov_cond (ov_cond)
   );

   vfs_blank #(
      .CODE_W      (CODE_W),
      .INIT_TGT    (INIT_TGT),
      .SMALL_STEP  (SMALL_STEP),
      .HIGH_BUS    (HIGH_BUS),
      .UV_BLANK    (UV_BLANK),
      .OVB_SMALL_HI(OVB_SMALL_HI),
      .OVB_SMALL_LO(OVB_SMALL_LO),
      .OVB_BIG_HI  (OVB_BIG_HI),
      .OVB_BIG_LO  (OVB_BIG_LO)
   ) i_blank (
      .clk      (clk),
      .rst_n    (rst_n),
      .tgt_chg  (tgt_chg),
      .tgt_code (tgt_code),
      .smp_valid(smp_valid),
      .smp_code (smp_code),
      .tick     (tick_1ms),
      .uv_blank (uv_blank),
      .ov_blank (ov_blank)
   );

   assign uv_clr = !run || uv_blank;
   assign ov_clr = !run || ov_blank;

   vfs_qualify #(.LIMIT(UV_QUAL)) i_uv_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (uv_clr),
      .smp_valid(smp_valid),
      .cond     (uv_cond),
      .tick     (tick_1ms),
      .trip     (uv_trip)
   );

   vfs_qualify #(.LIMIT(OV_QUAL)) i_ov_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ov_clr),
      .smp_valid(smp_valid),
      .cond     (ov_cond),
      .tick     (tick_1ms),
      .trip     (ov_trip)
   );

   vfs_restart #(.RESTART_TICKS(RESTART_TICKS)) i_restart (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_valid(smp_valid),
      .uv_cond  (uv_cond),
      .ov_cond  (ov_cond),
      .uv_trip  (uv_trip),
      .ov_trip  (ov_trip),
      .tick     (tick_1ms),
      .run      (run),
      .uv_fault (uv_fault),
      .ov_fault (ov_fault)
   );

   assign lsw_en      = run;
   assign sr_gate_off = ov_blank;

endmodule

// File: rtl/vfs_checks.sv
module vfs_checks #(
   parameter int unsigned CODE_W        = 10,
   parameter int unsigned RESTART_TICKS = 2000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              smp_valid,
   input logic [CODE_W-1:0] tgt_code,
   input logic              tgt_chg,
   input logic              tick_1ms,
   input logic              uv_fault,
   input logic              ov_fault,
   input logic              lsw_en,
   input logic              sr_gate_off
);
   int unsigned hold_ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_ticks <= 0;
      end else if (!(uv_fault || ov_fault)) begin
         hold_ticks <= 0;
      end else if (tick_1ms) begin
         hold_ticks <= hold_ticks + 1;
      end
   end

   // R10: flags are only visible while the switch is open
   p_flags_switch_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lsw_en |-> !(uv_fault || ov_fault));

   // R10: the switch only opens because of a reported fault
   p_drop_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lsw_en) |-> (uv_fault || ov_fault));

   // R10: the restart interval spans exactly the configured tick count
   p_holdoff_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lsw_en) && $past(uv_fault || ov_fault)) |-> (hold_ticks == RESTART_TICKS));

   // R11: a first close of the switch follows a valid sample
   p_first_close_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lsw_en) && !$past(uv_fault || ov_fault)) |-> $past(smp_valid));

   // R8: a downward target step opens the rectifier-disable window
   p_down_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_chg && (tgt_code < $past(tgt_code))) |=> sr_gate_off);

   // R8: no over-voltage fault is reported inside the window
   p_ov_blanked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sr_gate_off |-> !$rose(ov_fault));

   // R7: an upward step cannot be followed at once by an under-voltage report
   p_up_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_chg && (tgt_code > $past(tgt_code)) && !uv_fault) |=> !uv_fault);

endmodule

bind vbus_fault_supervisor vfs_checks #(
   .CODE_W       (CODE_W),
   .RESTART_TICKS(RESTART_TICKS)
) i_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_valid  (smp_valid),
   .tgt_code   (tgt_code),
   .tgt_chg    (tgt_chg),
   .tick_1ms   (tick_1ms),
   .uv_fault   (uv_fault),
   .ov_fault   (ov_fault),
   .lsw_en     (lsw_en),
   .sr_gate_off(sr_gate_off)
);

// File: tb/test_vbus_fault_supervisor.sv
module test_vbus_fault_supervisor;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       smp_valid = 1'b0;
   logic [9:0] smp_code = 10'd200;
   logic [9:0] tgt_code = 10'd200;
   logic       tgt_chg = 1'b0;
   logic       tick_1ms = 1'b0;
   logic       uv_fault, ov_fault, lsw_en, sr_gate_off;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vbus_fault_supervisor i_vbus_fault_supervisor (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp_valid  (smp_valid),
      .smp_code   (smp_code),
      .tgt_code   (tgt_code),
      .tgt_chg    (tgt_chg),
      .tick_1ms   (tick_1ms),
      .uv_fault   (uv_fault),
      .ov_fault   (ov_fault),
      .lsw_en     (lsw_en),
      .sr_gate_off(sr_gate_off)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick_1ms = 1'b1;
         @(negedge clk) tick_1ms = 1'b0;
         @(negedge clk);
         @(negedge clk);
      end
   endtask

   task automatic sample(input int code);
      @(negedge clk);
      smp_code  = 10'(code);
      smp_valid = 1'b1;
      @(negedge clk) smp_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic retarget(input int code);
      @(negedge clk);
      tgt_code = 10'(code);
      tgt_chg  = 1'b1;
      @(negedge clk) tgt_chg = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset;
      check("R11", "lsw_en after reset", int'(lsw_en), 0);
      check("R11", "flags after reset", int'({uv_fault, ov_fault}), 0);
      check("R11", "sr_gate_off after reset", int'(sr_gate_off), 0);
      sample(300);
      check("R11", "lsw_en after faulty first sample", int'(lsw_en), 0);
      sample(200);
      check("R11", "lsw_en after clean sample", int'(lsw_en), 1);
   endtask

   task automatic t_uv_qualify;
      sample(140);
      ticks(70);
      check("R1", "uv at threshold code 140", int'(uv_fault), 0);
      sample(139);
      ticks(59);
      check("R4", "uv after 59 ticks", int'(uv_fault), 0);
      check("R4", "lsw_en after 59 ticks", int'(lsw_en), 1);
      ticks(1);
      check("R4", "uv after 60 ticks", int'(uv_fault), 1);
      check("R10", "lsw_en on uv fault", int'(lsw_en), 0);
      ticks(1999);
      check("R10", "uv held at 1999 ticks", int'(uv_fault), 1);
      check("R10", "lsw_en open at 1999 ticks", int'(lsw_en), 0);
      ticks(1);
      check("R10", "uv cleared at 2000 ticks", int'(uv_fault), 0);
      check("R10", "lsw_en back at 2000 ticks", int'(lsw_en), 1);
      ticks(80);
      check("R10", "qualification discarded after restart", int'(uv_fault), 0);
      sample(200);
   endtask

   task automatic t_clear_on_good;
      sample(139);
      ticks(30);
      sample(200);
      ticks(40);
      check("R6", "uv after clean sample", int'(uv_fault), 0);
      sample(250);
      ticks(20);
      sample(200);
      ticks(20);
      check("R6", "ov after clean sample", int'(ov_fault), 0);
   endtask

   task automatic t_ov_qualify;
      sample(243);
      ticks(40);
      check("R2", "ov at threshold code 243", int'(ov_fault), 0);
      sample(244);
      ticks(30);
      check("R5", "ov after 30 ticks", int'(ov_fault), 0);
      ticks(1);
      check("R5", "ov after 31 ticks", int'(ov_fault), 1);
      check("R5", "uv during ov fault", int'(uv_fault), 0);
      check("R10", "lsw_en on ov fault", int'(lsw_en), 0);
      ticks(2000);
      check("R10", "lsw_en after ov restart", int'(lsw_en), 1);
      sample(200);
   endtask

   task automatic t_ceiling;
      retarget(900);
      sample(900);
      sample(980);
      ticks(40);
      check("R3", "ov at ceiling code 980", int'(ov_fault), 0);
      sample(981);
      ticks(30);
      check("R3", "ov above ceiling after 30 ticks", int'(ov_fault), 0);
      ticks(1);
      check("R3", "ov above ceiling after 31 ticks", int'(ov_fault), 1);
      ticks(2000);
      retarget(200);
      sample(200);
      ticks(56);
      check("R3", "lsw_en after ceiling restart", int'(lsw_en), 1);
   endtask

   task automatic t_up_blank;
      retarget(400);
      ticks(199);
      sample(200);
      ticks(61);
      check("R7", "uv for sample inside window", int'(uv_fault), 0);
      sample(200);
      ticks(59);
      check("R7", "uv 59 ticks after window", int'(uv_fault), 0);
      ticks(1);
      check("R7", "uv 60 ticks after window", int'(uv_fault), 1);
      ticks(2000);
      sample(400);
   endtask

   task automatic t_down_blank;
      retarget(390);
      check("R8", "sr off after small step low bus", int'(sr_gate_off), 1);
      ticks(18);
      check("R8", "sr off at 18 ticks", int'(sr_gate_off), 1);
      ticks(1);
      check("R8", "sr on at 19 ticks", int'(sr_gate_off), 0);
      retarget(600);
      sample(600);
      retarget(590);
      ticks(6);
      check("R8", "sr off at 6 ticks small high", int'(sr_gate_off), 1);
      ticks(1);
      check("R8", "sr on at 7 ticks small high", int'(sr_gate_off), 0);
      retarget(570);
      ticks(6);
      check("R8", "step of 20 codes at 6 ticks", int'(sr_gate_off), 1);
      ticks(1);
      check("R8", "step of 20 codes at 7 ticks", int'(sr_gate_off), 0);
      sample(570);
      retarget(549);
      ticks(55);
      check("R8", "step of 21 codes at 55 ticks", int'(sr_gate_off), 1);
      ticks(1);
      check("R8", "step of 21 codes at 56 ticks", int'(sr_gate_off), 0);
      sample(400);
      retarget(200);
      ticks(199);
      check("R8", "big step low bus at 199 ticks", int'(sr_gate_off), 1);
      sample(400);
      ticks(1);
      check("R8", "big step low bus at 200 ticks", int'(sr_gate_off), 0);
      ticks(40);
      check("R8", "ov for sample inside window", int'(ov_fault), 0);
      check("R8", "lsw_en after blanked ov sample", int'(lsw_en), 1);
      sample(200);
   endtask

   task automatic t_retrigger;
      retarget(600);
      sample(600);
      retarget(400);
      ticks(30);
      check("R9", "first window open at 30 ticks", int'(sr_gate_off), 1);
      retarget(390);
      ticks(6);
      check("R9", "restarted window at 6 ticks", int'(sr_gate_off), 1);
      ticks(1);
      check("R9", "restarted window closed at 7 ticks", int'(sr_gate_off), 0);
      sample(390);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_uv_qualify();
      t_clear_on_good();
      t_ov_qualify();
      t_ceiling();
      t_up_blank();
      t_down_blank();
      t_retrigger();
      finish_run();
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      finish_run();
   end

endmodule